// File: doc/BRIEF.md
# Time-Shared Laser Driver Bias and Swing Controller

This block closes the power and swing control loops of four laser-driver channels through one shared analog-to-digital converter. It owns the two-level sense selection: first a channel, then which quantity of that channel is routed to the converter, either the output common-mode level or the output amplitude. After each new selection it waits a programmable number of clock cycles so the sensed voltage can settle. It then pulses a conversion start and waits for the converter's done strobe.

Each 10-bit result is compared with a per-channel target. A common-mode reading adjusts that channel's bias word. An amplitude reading adjusts that channel's modulation word. The law is a fixed-size step toward the target, skipped when the error lies inside a programmable deadband, and the result saturates at the ends of the code range. Each of the eight registered 10-bit words drives a current DAC spanning 5 to 20 mA over its 1024 codes. Scanning never stops. Clearing the enable input freezes every word in place.

Top module: `tdm_power_ctrl`

## Requirements
- R1: After reset, all eight control words hold midscale (512), the selection points at channel 0 common-mode (`sense_ch`=0, `sense_amp`=0), and `conv_start` is low.
- R2: Slots are visited in order channel 0 common-mode, channel 0 amplitude, channel 1 common-mode, and so on up to channel 3 amplitude, then back to channel 0 common-mode. `sense_ch` is the channel number and `sense_amp` is 1 for amplitude and 0 for common-mode. The selection advances only on the clock edge that accepts a done strobe.
- R3: When the selection changes on clock edge E, `conv_start` goes high on edge E+`settle_cycles`+1. A value of 0 therefore gives a start on the very next edge. The selection does not change while a start is pending.
- R4: `conv_start` is high for exactly one cycle per slot. A `conv_done` that arrives while no conversion is outstanding is ignored: no word changes and the selection does not advance.
- R5: An accepted result from a common-mode slot writes only that channel's bias word. A result from an amplitude slot writes only that channel's modulation word. No word changes on any other edge.
- R6: While `loop_en` is low, no control word changes, and scanning and conversions continue.
- R7: If the result exceeds target plus `deadband`, the word drops by `step_size`. If it is below target minus `deadband`, the word rises by `step_size`. Otherwise the word is unchanged.
- R8: A step that would pass below 0 yields 0, and a step that would pass above 1023 yields 1023.
- R9: With sensed codes that rise linearly with each word, and a step small enough for the deadband window, every word settles to a value whose sensed code lies within `deadband` of its target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loop_en | input | 1 | 1 lets results update words, 0 freezes all words |
| settle_cycles | input | 12 | Settling wait after each selection change, in cycles |
| step_size | input | 4 | Correction applied per update |
| deadband | input | 10 | Error magnitude that causes no correction |
| cm_targets | input | 40 | Common-mode targets, channel n at bits [10n+9:10n] |
| amp_targets | input | 40 | Amplitude targets, channel n at bits [10n+9:10n] |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_done | input | 1 | Converter result valid strobe |
| conv_code | input | 10 | Converter result |
| sense_ch | output | 2 | Selected channel |
| sense_amp | output | 1 | Selected quantity: 0 common-mode, 1 amplitude |
| bias_words | output | 40 | Bias control words, channel n at bits [10n+9:10n] |
| mod_words | output | 40 | Modulation control words, channel n at bits [10n+9:10n] |

## Verification
The bench varies the settling wait down to zero and in the middle of a scan. A design that counts the wait one cycle short, or that latches its length, drifts off the reference start times. A stray done strobe is injected while the controller is still settling. A design that accepts it would advance its slot and push a word upward on a zero reading. Targets outside the reachable code range drive words into both rails, which exposes wraparound past 0 or 1023. A freeze period with changed targets catches any write that slips past the enable.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
   typedef enum logic {
      ST_SETTLE = 1'b0,
      ST_WAIT   = 1'b1
   } seq_state_t;
endpackage

// File: rtl/tdm_step_law.sv
module tdm_step_law #(
   parameter int CODE_W = 10,
   parameter int STEP_W = 4
) (
   input  logic [CODE_W-1:0] cur_word,
   input  logic [CODE_W-1:0] code,
   input  logic [CODE_W-1:0] target,
   input  logic [STEP_W-1:0] step,
   input  logic [CODE_W-1:0] band,
   output logic [CODE_W-1:0] nxt_word
);
   localparam int EW = CODE_W + 2;
   localparam logic [CODE_W:0] TOP = {1'b0, {CODE_W{1'b1}}};

   logic signed [EW-1:0] err;
   logic signed [EW-1:0] band_s;
   logic [CODE_W:0]      step_x;
   logic [CODE_W:0]      up_sum;

   initial begin
      assert (CODE_W + 1 > STEP_W) else $error("step wider than code");
   end

   always_comb begin
      err    = $signed({2'b00, code}) - $signed({2'b00, target});
      band_s = $signed({2'b00, band});
      step_x = {{(CODE_W + 1 - STEP_W){1'b0}}, step};
      up_sum = {1'b0, cur_word} + step_x;
      if (err > band_s) begin
         nxt_word = ({1'b0, cur_word} < step_x) ? '0 : cur_word - step_x[CODE_W-1:0];
      end else if (-err > band_s) begin
         nxt_word = (up_sum > TOP) ? TOP[CODE_W-1:0] : up_sum[CODE_W-1:0];
      end else begin
         nxt_word = cur_word;
      end
   end
endmodule

// File: rtl/tdm_scan_seq.sv
module tdm_scan_seq
   import tdm_pkg::*;
#(
   parameter int NUM_CH  = 4,
   parameter int DWELL_W = 12
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [DWELL_W-1:0]         settle_cycles,
   input  logic                       conv_done,
   output logic [$clog2(NUM_CH)-1:0]  sense_ch,
   output logic                       sense_amp,
   output logic                       conv_start,
   output logic                       upd_fire
);
   localparam int CH_W   = $clog2(NUM_CH);
   localparam int SLOT_W = CH_W + 1;
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(2 * NUM_CH - 1);

   seq_state_t         state_q;
   logic [DWELL_W-1:0] cnt_q;
   logic [SLOT_W-1:0]  slot_q;
   logic [SLOT_W-1:0]  slot_nxt;

   initial begin
      assert (NUM_CH >= 2) else $error("need at least two channels");
      assert (DWELL_W >= 1) else $error("dwell width must be positive");
   end

   assign sense_ch  = slot_q[SLOT_W-1:1];
   assign sense_amp = slot_q[0];
   assign upd_fire  = (state_q == ST_WAIT) && conv_done;

   generate
      if ((NUM_CH & (NUM_CH - 1)) == 0) begin : g_pow2_wrap
         assign slot_nxt = slot_q + 1'b1;
      end else begin : g_cmp_wrap
         assign slot_nxt = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_SETTLE;
         cnt_q      <= '0;
         slot_q     <= '0;
         conv_start <= 1'b0;
      end else begin
         conv_start <= 1'b0;
         case (state_q)
            ST_SETTLE: begin
               if (cnt_q >= settle_cycles) begin
                  state_q    <= ST_WAIT;
                  conv_start <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: begin
               if (conv_done) begin
                  state_q <= ST_SETTLE;
                  cnt_q   <= '0;
                  slot_q  <= slot_nxt;
               end
            end
         endcase
      end
   end

   // R4: start is a single-cycle pulse
   a_r4_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   // R3: selection is steady at the moment a start goes out
   a_r3_sel_steady: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(conv_start) |-> ($stable(sense_ch) && $stable(sense_amp)));

   // R2: selection moves only after a done strobe
   a_r2_adv_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sense_ch) || !$stable(sense_amp)) |-> $past(conv_done));
endmodule

// File: rtl/tdm_word_bank.sv
module tdm_word_bank #(
   parameter int NUM_CH    = 4,
   parameter int CODE_W    = 10,
   parameter int STEP_W    = 4,
   parameter int INIT_WORD = 512
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       loop_en,
   input  logic                       upd_fire,
   input  logic [$clog2(NUM_CH)-1:0]  sense_ch,
   input  logic                       sense_amp,
   input  logic [CODE_W-1:0]          conv_code,
   input  logic [NUM_CH*CODE_W-1:0]   cm_targets,
   input  logic [NUM_CH*CODE_W-1:0]   amp_targets,
   input  logic [STEP_W-1:0]          step_size,
   input  logic [CODE_W-1:0]          deadband,
   output logic [NUM_CH*CODE_W-1:0]   bias_words,
   output logic [NUM_CH*CODE_W-1:0]   mod_words
);
   logic [CODE_W-1:0] bias_q [NUM_CH];
   logic [CODE_W-1:0] mod_q  [NUM_CH];
   logic [CODE_W-1:0] cur_word;
   logic [CODE_W-1:0] cur_tgt;
   logic [CODE_W-1:0] nxt_word;
   logic              wr_ok;

   initial begin
      assert (INIT_WORD >= 0 && INIT_WORD < (1 << CODE_W)) else $error("reset word out of range");
   end

   assign wr_ok    = upd_fire && loop_en;
   assign cur_word = sense_amp ? mod_q[sense_ch] : bias_q[sense_ch];
   assign cur_tgt  = sense_amp ? amp_targets[sense_ch*CODE_W +: CODE_W]
                               : cm_targets[sense_ch*CODE_W +: CODE_W];

   tdm_step_law #(.CODE_W(CODE_W), .STEP_W(STEP_W)) u_law (
      .cur_word (cur_word),
      .code     (conv_code),
      .target   (cur_tgt),
      .step     (step_size),
      .band     (deadband),
      .nxt_word (nxt_word)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bias_q[c] <= CODE_W'(INIT_WORD);
            mod_q[c]  <= CODE_W'(INIT_WORD);
         end else if (wr_ok && (sense_ch == c)) begin
            if (sense_amp) mod_q[c]  <= nxt_word;
            else           bias_q[c] <= nxt_word;
         end
      end
      assign bias_words[c*CODE_W +: CODE_W] = bias_q[c];
      assign mod_words[c*CODE_W +: CODE_W]  = mod_q[c];

      // R7: a word never moves by more than one step
      a_r7_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
         ((int'(bias_q[c]) - int'($past(bias_q[c])) <= int'($past(step_size))) &&
          (int'($past(bias_q[c])) - int'(bias_q[c]) <= int'($past(step_size))) &&
          (int'(mod_q[c]) - int'($past(mod_q[c])) <= int'($past(step_size))) &&
          (int'($past(mod_q[c])) - int'(mod_q[c]) <= int'($past(step_size)))));
   end

   // R6: frozen loop leaves all words in place
   a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(loop_en) |-> ($stable(bias_words) && $stable(mod_words)));

   // R5: words only move on an accepted result
   a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(upd_fire) |-> ($stable(bias_words) && $stable(mod_words)));
endmodule

// File: rtl/tdm_power_ctrl.sv
module tdm_power_ctrl #(
   parameter int NUM_CH    = 4,
   parameter int CODE_W    = 10,
   parameter int DWELL_W   = 12,
   parameter int STEP_W    = 4,
   parameter int INIT_WORD = 512
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       loop_en,
   input  logic [DWELL_W-1:0]         settle_cycles,
   input  logic [STEP_W-1:0]          step_size,
   input  logic [CODE_W-1:0]          deadband,
   input  logic [NUM_CH*CODE_W-1:0]   cm_targets,
   input  logic [NUM_CH*CODE_W-1:0]   amp_targets,
   output logic                       conv_start,
   input  logic                       conv_done,
   input  logic [CODE_W-1:0]          conv_code,
   output logic [$clog2(NUM_CH)-1:0]  sense_ch,
   output logic                       sense_amp,
   output logic [NUM_CH*CODE_W-1:0]   bias_words,
   output logic [NUM_CH*CODE_W-1:0]   mod_words
);
   logic upd_fire;

   tdm_scan_seq #(.NUM_CH(NUM_CH), .DWELL_W(DWELL_W)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .settle_cycles (settle_cycles),
      .conv_done     (conv_done),
      .sense_ch      (sense_ch),
      .sense_amp     (sense_amp),
      .conv_start    (conv_start),
      .upd_fire      (upd_fire)
   );

   tdm_word_bank #(
      .NUM_CH(NUM_CH), .CODE_W(CODE_W), .STEP_W(STEP_W), .INIT_WORD(INIT_WORD)
   ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .loop_en     (loop_en),
      .upd_fire    (upd_fire),
      .sense_ch    (sense_ch),
      .sense_amp   (sense_amp),
      .conv_code   (conv_code),
      .cm_targets  (cm_targets),
      .amp_targets (amp_targets),
      .step_size   (step_size),
      .deadband    (deadband),
      .bias_words  (bias_words),
      .mod_words   (mod_words)
   );
endmodule

// File: tb/tdm_power_ctrl_tb.sv
module tdm_power_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        loop_en = 1'b1;
   logic [11:0] settle_cycles = 12'd5;
   logic [3:0]  step_size = 4'd4;
   logic [9:0]  deadband = 10'd4;
   logic [39:0] cm_targets, amp_targets;
   logic        conv_start;
   logic        conv_done = 1'b0;
   logic [9:0]  conv_code = '0;
   logic [1:0]  sense_ch;
   logic        sense_amp;
   logic [39:0] bias_words, mod_words;

   int checks = 0, errors = 0;
   bit cmp_on = 0, spur_req = 0, finished = 0;

   always #4 clk = ~clk;

   tdm_power_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .settle_cycles(settle_cycles),
      .step_size(step_size), .deadband(deadband), .cm_targets(cm_targets),
      .amp_targets(amp_targets), .conv_start(conv_start), .conv_done(conv_done),
      .conv_code(conv_code), .sense_ch(sense_ch), .sense_amp(sense_amp),
      .bias_words(bias_words), .mod_words(mod_words)
   );

   function automatic int wsel(logic [39:0] v, int ch);
      return int'(v[ch*10 +: 10]);
   endfunction

   // linear plant: sensed code from control word
   function automatic int plant(int w, int ch, bit amp);
      int v = (w * 3) / 4 + 20 * (ch + 1) + (amp ? 10 : 0);
      return (v > 1023) ? 1023 : v;
   endfunction

   function automatic int law(int cur, int code, int tgt, int st, int db);
      if (code > tgt + db) return (cur - st < 0) ? 0 : cur - st;
      if (code < tgt - db) return (cur + st > 1023) ? 1023 : cur + st;
      return cur;
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // reference model, updated on every rising edge
   int  m_bias[4], m_mod[4];
   int  m_slot, m_cnt;
   bit  m_wait, m_start;
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < 4; c++) begin m_bias[c] = 512; m_mod[c] = 512; end
         m_slot = 0; m_cnt = 0; m_wait = 0; m_start = 0;
      end else if (!m_wait) begin
         if (m_cnt >= int'(settle_cycles)) begin m_wait = 1; m_start = 1; end
         else begin m_cnt++; m_start = 0; end
      end else begin
         m_start = 0;
         if (conv_done) begin
            if (loop_en) begin
               if (m_slot % 2 == 1)
                  m_mod[m_slot/2] = law(m_mod[m_slot/2], int'(conv_code),
                     wsel(amp_targets, m_slot/2), int'(step_size), int'(deadband));
               else
                  m_bias[m_slot/2] = law(m_bias[m_slot/2], int'(conv_code),
                     wsel(cm_targets, m_slot/2), int'(step_size), int'(deadband));
            end
            m_slot = (m_slot + 1) % 8;
            m_wait = 0;
            m_cnt = 0;
         end
      end
   end

   // per-cycle comparison and converter model, both on the falling edge
   bit busy = 0;
   int lat = 0;
   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         check(int'(sense_ch) == m_slot / 2 && int'(sense_amp) == m_slot % 2,
               "R2", "slot", int'({sense_ch, sense_amp}), m_slot);
         check(conv_start == m_start, "R3 R4", "conv_start", int'(conv_start), int'(m_start));
         for (int c = 0; c < 4; c++) begin
            check(wsel(bias_words, c) == m_bias[c], "R5 R7", "bias word", wsel(bias_words, c), m_bias[c]);
            check(wsel(mod_words, c) == m_mod[c], "R5 R7", "mod word", wsel(mod_words, c), m_mod[c]);
         end
      end
      conv_done = 1'b0;
      if (busy) begin
         if (lat == 0) begin
            conv_done = 1'b1;
            conv_code = 10'(plant(sense_amp ? wsel(mod_words, sense_ch) : wsel(bias_words, sense_ch),
                                  int'(sense_ch), sense_amp));
            busy = 0;
         end else lat--;
      end else if (conv_start) begin
         busy = 1; lat = 2;
      end else if (spur_req && rst_n) begin
         conv_done = 1'b1;   // stray strobe while settling (R4)
         conv_code = 10'd0;
         spur_req = 0;
      end
   end

   task automatic run(int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int absd(int a, int b);
      return (a > b) ? a - b : b - a;
   endfunction

   initial begin
      cm_targets  = {10'd780, 10'd300, 10'd650, 10'd200};
      amp_targets = {10'd120, 10'd500, 10'd150, 10'd700};
      run(4);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      for (int c = 0; c < 4; c++) begin
         check(wsel(bias_words, c) == 512, "R1", "reset bias", wsel(bias_words, c), 512);
         check(wsel(mod_words, c) == 512, "R1", "reset mod", wsel(mod_words, c), 512);
      end
      check(sense_ch == 0 && sense_amp == 0, "R1", "reset slot", int'({sense_ch, sense_amp}), 0);
      check(conv_start == 0, "R1", "reset start", int'(conv_start), 0);
      cmp_on = 1;
      run(3000);
      #1 spur_req = 1;
      run(400);
      #1 spur_req = 1;
      run(12000);
      // R9 convergence
      for (int c = 0; c < 4; c++) begin
         check(absd(plant(wsel(bias_words, c), c, 0), wsel(cm_targets, c)) <= 4, "R9",
               "cm settle", plant(wsel(bias_words, c), c, 0), wsel(cm_targets, c));
         check(absd(plant(wsel(mod_words, c), c, 1), wsel(amp_targets, c)) <= 4, "R9",
               "amp settle", plant(wsel(mod_words, c), c, 1), wsel(amp_targets, c));
      end
      // R8 saturation with zero dwell and a large step
      #1;
      settle_cycles = 12'd0;
      step_size = 4'd15;
      cm_targets[9:0] = 10'd1023;
      amp_targets[19:10] = 10'd0;
      run(6000);
      check(wsel(bias_words, 0) == 1023, "R8", "upper clamp", wsel(bias_words, 0), 1023);
      check(wsel(mod_words, 1) == 0, "R8", "lower clamp", wsel(mod_words, 1), 0);
      // R6 freeze
      #1;
      settle_cycles = 12'd9;
      loop_en = 1'b0;
      begin
         logic [39:0] b0, m0;
         b0 = bias_words; m0 = mod_words;
         cm_targets = '0;
         amp_targets = {4{10'd1000}};
         run(2000);
         check(bias_words == b0, "R6", "bias frozen", int'(bias_words[9:0]), int'(b0[9:0]));
         check(mod_words == m0, "R6", "mod frozen", int'(mod_words[9:0]), int'(m0[9:0]));
      end
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule